// File: doc/BRIEF.md
# Timer Event Output Generator

This block turns the counter's overflow and compare-match strobes into the level on the timer's external output pin. The counter core raises a one-clock strobe when it wraps and another when it reaches the compare value. The control fields pick which of those strobes act on the pin, and whether an acting strobe flips the pin or sends a one-clock pulse. A programmable idle level is the pin's level whenever the timer is not running or triggering is switched off.

The pin is shared with the capture path. While the shared direction control marks it as an input, the generator leaves its output register alone. Counting, capture and register access belong to neighbouring blocks. The pin register is the only state, so every change is visible one clock after the inputs that cause it.

Top module: `tmr_evt_out`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pin_out` becomes 0 at that edge, whatever the other inputs are.
- R2: When `pin_is_input` is 1, `pin_out` keeps its value across the edge, whatever strobes, run flag or other controls are present.
- R3: With `pin_is_input` 0 and `timer_run` 0, `pin_out` takes the value of `idle_lvl` at the next edge, and strobes are ignored.
- R4: `trig_sel` encodes 0 = off, 1 = overflow only, 2 = overflow and match, 3 = unused. With the value 0 or 3 and the pin an output, `pin_out` takes `idle_lvl` at the next edge, and strobes are ignored.
- R5: An overflow strobe acts on the pin when `trig_sel` is 1 or 2 and the timer runs.
- R6: A match strobe acts on the pin only when `trig_sel` is 2. With `trig_sel` at 1 it leaves the pin unchanged.
- R7: With `toggle_mode` 1, each clock that has an acting strobe inverts `pin_out`, and a clock with none leaves `pin_out` unchanged.
- R8: With `toggle_mode` 0, an acting strobe drives `pin_out` to the inverse of `idle_lvl` for exactly one clock, after which it returns to `idle_lvl`.
- R9: In toggle mode, an overflow and a match strobe arriving on the same clock with `trig_sel` 2 invert `pin_out` only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| timer_run | input | 1 | The counter is running |
| ovf_stb | input | 1 | One-clock overflow strobe from the counter |
| match_stb | input | 1 | One-clock compare-match strobe from the counter |
| trig_sel | input | 2 | Event selection: 0 off, 1 overflow, 2 overflow and match, 3 treated as off |
| toggle_mode | input | 1 | 1 = invert on each event, 0 = one-clock pulse |
| idle_lvl | input | 1 | Pin level while idle |
| pin_is_input | input | 1 | Shared direction control: 1 means the pin is an input, so no update |
| pin_out | output | 1 | Registered output pin level |

## Verification
The strobes are applied alone, together and not at all, under each trigger selection. This shows that overflow acts under both active selections, that match acts only under the second one, and that the unused code behaves like off. Both output styles are tried with both idle levels. A lone pulse must be exactly one clock wide and the opposite of the idle level, while a toggle must hold between events and flip only once when both strobes coincide. Stopping the timer and setting the pin to input are each applied with strobes present and with an idle level opposite to the current pin, so that the forced idle and the frozen pin can be told apart.

// File: rtl/tmr_evt_out_pkg.sv
// Package: shared encodings for the timer event output generator.
// Assumes: the trigger select is a 2-bit field whose code 3 is unused.
package tmr_evt_out_pkg;

    // Trigger select codes seen on trig_sel
    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_OVF  = 2'd1,
        TRIG_BOTH = 2'd2,
        TRIG_RSV  = 2'd3
    } trig_sel_e;

    // Output-style controls consumed by the pin driver
    typedef struct packed {
        logic hold;      // pin is an input: freeze the register
        logic toggle;    // 1 = invert per event, 0 = pulse
        logic idle;      // idle pin level
    } pin_ctl_t;

endpackage

// File: rtl/tmr_evt_sel.sv
// Module: tmr_evt_sel
// Decides whether triggering is live this clock and whether an acting
// event is present. Purely combinational.
// Assumes: strobes are single-clock pulses from the counter core.
module tmr_evt_sel
    import tmr_evt_out_pkg::*;
(
    input  logic       timer_run,
    input  logic       ovf_stb,
    input  logic       match_stb,
    input  logic [1:0] trig_sel,
    output logic       trig_live,
    output logic       evt_hit
);

    trig_sel_e sel;

    // Qualify the strobes by the selected trigger code
    always_comb begin
        sel       = trig_sel_e'(trig_sel);
        trig_live = 1'b0;
        evt_hit   = 1'b0;
        case (sel)
            TRIG_OVF: begin
                trig_live = timer_run;
                evt_hit   = timer_run & ovf_stb;
            end
            TRIG_BOTH: begin
                trig_live = timer_run;
                evt_hit   = timer_run & (ovf_stb | match_stb);
            end
            default: begin
                trig_live = 1'b0;
                evt_hit   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tmr_pin_drv.sv
// Module: tmr_pin_drv
// Holds the output pin register and computes its next level from the
// qualified event and the output-style controls.
// Assumes: evt_hit is already qualified by the run flag and the trigger code.
module tmr_pin_drv
    import tmr_evt_out_pkg::*;
#(
    parameter logic RESET_LVL = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pin_ctl_t ctl,
    input  logic     trig_live,
    input  logic     evt_hit,
    output logic     pin_q
);

    logic pin_d;

    // Next pin level: freeze, idle, toggle or pulse
    always_comb begin
        if (ctl.hold) begin
            pin_d = pin_q;
        end else if (!trig_live) begin
            pin_d = ctl.idle;
        end else if (ctl.toggle) begin
            pin_d = evt_hit ? ~pin_q : pin_q;
        end else begin
            pin_d = evt_hit ? ~ctl.idle : ctl.idle;
        end
    end

    // Pin register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= RESET_LVL;
        end else begin
            pin_q <= pin_d;
        end
    end

endmodule

// File: rtl/tmr_evt_out.sv
// Module: tmr_evt_out (top)
// Drives the timer output pin from overflow and match strobes under the
// trigger select, output style, idle level and shared direction controls.
// Assumes: all inputs are synchronous to clk; output is registered.
module tmr_evt_out
    import tmr_evt_out_pkg::*;
#(
    parameter logic RESET_LVL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       timer_run,
    input  logic       ovf_stb,
    input  logic       match_stb,
    input  logic [1:0] trig_sel,
    input  logic       toggle_mode,
    input  logic       idle_lvl,
    input  logic       pin_is_input,
    output logic       pin_out
);

    logic     trig_live;
    logic     evt_hit;
    pin_ctl_t ctl;

    // Gather output-style controls for the driver
    always_comb begin
        ctl.hold   = pin_is_input;
        ctl.toggle = toggle_mode;
        ctl.idle   = idle_lvl;
    end

    tmr_evt_sel u_sel (
        .timer_run (timer_run),
        .ovf_stb   (ovf_stb),
        .match_stb (match_stb),
        .trig_sel  (trig_sel),
        .trig_live (trig_live),
        .evt_hit   (evt_hit)
    );

    tmr_pin_drv #(
        .RESET_LVL (RESET_LVL)
    ) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .trig_live (trig_live),
        .evt_hit   (evt_hit),
        .pin_q     (pin_out)
    );

endmodule

// File: rtl/tmr_evt_out_chk.sv
// Module: tmr_evt_out_chk
// Temporal checks on the pin generator's ports, bound to tmr_evt_out.
module tmr_evt_out_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       timer_run,
    input logic       ovf_stb,
    input logic       match_stb,
    input logic [1:0] trig_sel,
    input logic       toggle_mode,
    input logic       idle_lvl,
    input logic       pin_is_input,
    input logic       pin_out
);

    logic sel_act;
    assign sel_act = (trig_sel == 2'd1) || (trig_sel == 2'd2);

    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_is_input |=> pin_out == $past(pin_out));

    // R3
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_is_input && !timer_run) |=> pin_out == $past(idle_lvl));

    // R4
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_is_input && timer_run && !sel_act) |=> pin_out == $past(idle_lvl));

    // R6
    match_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_is_input && timer_run && trig_sel == 2'd1 && toggle_mode
         && match_stb && !ovf_stb) |=> $stable(pin_out));

    // R7
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_is_input && timer_run && sel_act && toggle_mode
         && !ovf_stb && !match_stb) |=> $stable(pin_out));

    // R8
    pulse_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_is_input && timer_run && sel_act && !toggle_mode && ovf_stb)
        |=> pin_out == !$past(idle_lvl));

    // R9
    both_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_is_input && timer_run && trig_sel == 2'd2 && toggle_mode
         && ovf_stb && match_stb) |=> pin_out != $past(pin_out));

endmodule

bind tmr_evt_out tmr_evt_out_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .timer_run    (timer_run),
    .ovf_stb      (ovf_stb),
    .match_stb    (match_stb),
    .trig_sel     (trig_sel),
    .toggle_mode  (toggle_mode),
    .idle_lvl     (idle_lvl),
    .pin_is_input (pin_is_input),
    .pin_out      (pin_out)
);

// File: tb/tmr_evt_out_test.sv
// Scoreboard bench: drive() applies one clock of stimulus at the falling
// edge and queues the expected pin; the monitor checks after each rising edge.
module tmr_evt_out_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       timer_run = 1'b0;
    logic       ovf_stb = 1'b0;
    logic       match_stb = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       toggle_mode = 1'b0;
    logic       idle_lvl = 1'b0;
    logic       pin_is_input = 1'b0;
    logic       pin_out;

    int    n_total = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    logic  exp_q[$];
    string tag_q[$];
    logic  model_pin = 1'b0;

    always #2 clk = ~clk;

    tmr_evt_out uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .timer_run    (timer_run),
        .ovf_stb      (ovf_stb),
        .match_stb    (match_stb),
        .trig_sel     (trig_sel),
        .toggle_mode  (toggle_mode),
        .idle_lvl     (idle_lvl),
        .pin_is_input (pin_is_input),
        .pin_out      (pin_out)
    );

    // Apply one clock of stimulus and queue the expected pin after the edge
    task automatic drive(input logic rst, input logic dir, input logic run,
                         input logic [1:0] sel, input logic tog,
                         input logic idl, input logic ovf, input logic mat,
                         input string tag);
        logic ev;
        @(negedge clk);
        rst_n = rst; pin_is_input = dir; timer_run = run; trig_sel = sel;
        toggle_mode = tog; idle_lvl = idl; ovf_stb = ovf; match_stb = mat;
        ev = ovf | (mat & (sel == 2'd2));
        if (!rst)                                  model_pin = 1'b0;
        else if (dir)                              model_pin = model_pin;
        else if (!run || sel == 2'd0 || sel == 2'd3) model_pin = idl;
        else if (tog)                              model_pin = ev ? ~model_pin : model_pin;
        else                                       model_pin = ev ? ~idl : idl;
        exp_q.push_back(model_pin);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_total++;
            if (pin_out !== e) begin
                n_bad++;
                $display("FAIL %s: pin_out=%b expected=%b", t, pin_out, e);
            end
        end
    end

    initial begin
        // R1: reset clears the pin even with idle high and strobes present
        drive(0, 0, 1, 2'd1, 1, 1, 1, 1, "R1");
        drive(0, 0, 0, 2'd0, 0, 1, 0, 0, "R1");
        // R3: stopped timer forces idle level, strobes ignored
        drive(1, 0, 0, 2'd2, 1, 1, 1, 1, "R3");
        drive(1, 0, 0, 2'd1, 0, 0, 1, 0, "R3");
        drive(1, 0, 0, 2'd2, 1, 1, 0, 1, "R3");
        // R4: trigger off and unused code 3 force idle
        drive(1, 0, 1, 2'd0, 1, 0, 1, 1, "R4");
        drive(1, 0, 1, 2'd0, 1, 1, 1, 0, "R4");
        drive(1, 0, 1, 2'd3, 1, 0, 1, 1, "R4");
        drive(1, 0, 1, 2'd3, 0, 1, 1, 0, "R4");
        // R5 / R7: overflow toggles under code 1
        drive(1, 0, 1, 2'd0, 1, 0, 0, 0, "R4");
        drive(1, 0, 1, 2'd1, 1, 0, 1, 0, "R5");
        drive(1, 0, 1, 2'd1, 1, 0, 0, 0, "R7");
        drive(1, 0, 1, 2'd1, 1, 0, 0, 0, "R7");
        drive(1, 0, 1, 2'd1, 1, 0, 1, 0, "R5");
        // R6: match ignored under code 1, acts under code 2
        drive(1, 0, 1, 2'd1, 1, 0, 0, 1, "R6");
        drive(1, 0, 1, 2'd2, 1, 0, 0, 1, "R6");
        drive(1, 0, 1, 2'd2, 1, 0, 1, 0, "R5");
        // R9: coincident strobes invert once
        drive(1, 0, 1, 2'd2, 1, 0, 1, 1, "R9");
        drive(1, 0, 1, 2'd2, 1, 0, 1, 1, "R9");
        drive(1, 0, 1, 2'd2, 1, 0, 0, 0, "R7");
        // R2: pin as input freezes the register
        drive(1, 1, 0, 2'd0, 1, 1, 1, 1, "R2");
        drive(1, 1, 1, 2'd2, 0, 1, 1, 0, "R2");
        drive(1, 1, 1, 2'd2, 1, 0, 1, 1, "R2");
        // R8: pulse mode with idle low
        drive(1, 0, 1, 2'd1, 0, 0, 0, 0, "R8");
        drive(1, 0, 1, 2'd1, 0, 0, 1, 0, "R8");
        drive(1, 0, 1, 2'd1, 0, 0, 0, 0, "R8");
        drive(1, 0, 1, 2'd1, 0, 0, 0, 1, "R6");
        // R8: pulse mode with idle high, match under code 2
        drive(1, 0, 1, 2'd2, 0, 1, 0, 0, "R8");
        drive(1, 0, 1, 2'd2, 0, 1, 0, 1, "R8");
        drive(1, 0, 1, 2'd2, 0, 1, 0, 0, "R8");
        drive(1, 0, 1, 2'd2, 0, 1, 1, 1, "R8");
        drive(1, 0, 1, 2'd2, 0, 1, 0, 0, "R8");
        // R2: freeze while an inverted pulse level is held
        drive(1, 0, 1, 2'd1, 0, 1, 1, 0, "R8");
        drive(1, 1, 1, 2'd1, 0, 1, 0, 0, "R2");
        drive(1, 0, 1, 2'd1, 0, 1, 0, 0, "R8");
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_total++;
            n_bad++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule